// File: doc/BRIEF.md
# External Interrupt Request Controller

This block conditions four external interrupt request pins and turns each into a pending signal for a downstream priority encoder. Each pin is brought into the clock domain by a synchroniser, then judged against a per-line sense type. Two of the types are levels, active high or active low, and pending simply follows the pin. The other two are edges, rising or falling, and a detected edge sets a sticky latch that software clears by writing a one.

All configuration lives in one 32-bit control word, reached through plain write and read strobes. The word holds a per-line enable, a per-line two-bit sense type, a per-line clear-on-write-one bit, a master enable for all external lines, and a routing bit for the critical line. Line 0 drives the critical-tier pending output. Lines 1 to 3 drive the main-tier pending outputs.

Register access completes in one cycle and carries no back-pressure. A write takes effect at the clock edge that samples the write strobe. While the read strobe is high, read data shows the current word, and it is zero while the strobe is low.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset the control word reads 0x00000000, all pending outputs are 0 and the routing output is 0.
- R2: Control bit (11 - n) enables line n (line 0 is bit 11, line 3 is bit 8). When that bit is 0, line n never asserts pending.
- R3: Writing 1 to control bit (27 - n) clears the edge latch of line n (line 0 is bit 27, line 3 is bit 24). These four bits always read back as 0.
- R4: The sense type of line n is held in control bits [23-2n : 22-2n]. Code 0 is active-high level, code 1 is rising edge, code 2 is falling edge and code 3 is active-low level. In an edge mode, an edge of the opposite direction sets nothing.
- R5: In an edge mode, a detected edge is held until it is cleared, even after the pin returns to its idle state. In a level mode, pending follows the synchronised pin and nothing is latched.
- R6: Control bit 12 is the master enable. While it is 0, no pending output is asserted. A latched edge survives the masked period and reappears when the bit is set again.
- R7: Control bit 0 drives the output crit_route. Line 0 drives crit_pend, and line n (n = 1..3) drives main_pend[n-1].
- R8: If a write-one clear of line n falls in the same cycle as a new edge detection on line n, the latch stays set.
- R9: Latency is counted in rising clock edges after a pin changes. A level-mode pending changes after 2 edges, and an edge-mode pending sets after 3 edges.
- R10: Control bits 31:28, 15:13 and 7:1 read back as 0, whatever value was written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control word write strobe |
| wdata | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rdata | output | 32 | Control word read data, zero when rd_en is low |
| irq_pin | input | 4 | Asynchronous external request pins, bit n is line n |
| crit_pend | output | 1 | Pending of line 0 toward the critical tier |
| main_pend | output | 3 | Pending of lines 1..3 toward the main tier |
| crit_route | output | 1 | Critical routing selection |

## Verification
The edge detector of a line and the write-one clear of that same line can act in the same cycle. The bench provokes this by raising a pin in rising-edge mode and counting the synchroniser stages. It then places the clearing write strobe on exactly the edge where the detection is presented to the latch. The result is judged at the ports: pending must stay high after that edge, and a later clear on its own must drop it.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int NUM_LINES  = 4;
  localparam int WORD_W     = 32;
  localparam int MASTER_BIT = 12;
  localparam int ROUTE_BIT  = 0;

  typedef enum logic [1:0] {
    SENSE_HIGH = 2'd0,
    SENSE_RISE = 2'd1,
    SENSE_FALL = 2'd2,
    SENSE_LOW  = 2'd3
  } sense_e;

  function automatic int en_pos(input int n);
    return 11 - n;
  endfunction

  function automatic int clr_pos(input int n);
    return 27 - n;
  endfunction

  function automatic int sense_pos(input int n);
    return 22 - 2 * n;
  endfunction
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q[0] <= d;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
    end
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/ext_irq_regs.sv
module ext_irq_regs
  import ext_irq_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [WORD_W-1:0]         wdata,
  input  logic                      rd_en,
  output logic [WORD_W-1:0]         rdata,
  output logic [NUM_LINES-1:0]      line_en,
  output logic [NUM_LINES-1:0][1:0] line_sense,
  output logic [NUM_LINES-1:0]      line_clr,
  output logic                      master_en,
  output logic                      route_crit
);
  logic [NUM_LINES-1:0]      en_q;
  logic [NUM_LINES-1:0][1:0] sense_q;
  logic                      master_q;
  logic                      route_q;
  logic [WORD_W-1:0]         word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= '0;
      sense_q  <= '0;
      master_q <= 1'b0;
      route_q  <= 1'b0;
    end else if (wr_en) begin
      for (int n = 0; n < NUM_LINES; n++) begin
        en_q[n]    <= wdata[en_pos(n)];
        sense_q[n] <= wdata[sense_pos(n) +: 2];
      end
      master_q <= wdata[MASTER_BIT];
      route_q  <= wdata[ROUTE_BIT];
    end
  end

  always_comb begin
    word = '0;
    for (int n = 0; n < NUM_LINES; n++) begin
      word[en_pos(n)]         = en_q[n];
      word[sense_pos(n) +: 2] = sense_q[n];
      line_clr[n]             = wr_en & wdata[clr_pos(n)];
    end
    word[MASTER_BIT] = master_q;
    word[ROUTE_BIT]  = route_q;
  end

  assign rdata      = rd_en ? word : '0;
  assign line_en    = en_q;
  assign line_sense = sense_q;
  assign master_en  = master_q;
  assign route_crit = route_q;
endmodule

// File: rtl/ext_irq_line.sv
module ext_irq_line
  import ext_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_s,
  input  logic [1:0] sense,
  input  logic       en,
  input  logic       master,
  input  logic       clr,
  output logic       pend
);
  logic prev_q;
  logic latch_q;
  logic is_edge;
  logic hit;
  logic level_act;

  assign is_edge   = (sense == SENSE_RISE) || (sense == SENSE_FALL);
  assign hit       = ((sense == SENSE_RISE) &&  pin_s && !prev_q) ||
                     ((sense == SENSE_FALL) && !pin_s &&  prev_q);
  assign level_act = (sense == SENSE_HIGH) ? pin_s : !pin_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      prev_q <= pin_s;
      if (!is_edge)  latch_q <= 1'b0;
      else if (hit)  latch_q <= 1'b1;
      else if (clr)  latch_q <= 1'b0;
    end
  end

  assign pend = master & en & (is_edge ? latch_q : level_act);

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> latch_q); // R8
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    is_edge && clr && !hit |=> !latch_q); // R3
  AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    is_edge && latch_q && !clr |=> latch_q); // R5
  AST_LEVEL_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    !is_edge |=> !latch_q); // R5
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wdata,
  input  logic        rd_en,
  output logic [31:0] rdata,
  input  logic [3:0]  irq_pin,
  output logic        crit_pend,
  output logic [2:0]  main_pend,
  output logic        crit_route
);
  logic [NUM_LINES-1:0]      pin_s;
  logic [NUM_LINES-1:0]      line_en;
  logic [NUM_LINES-1:0][1:0] line_sense;
  logic [NUM_LINES-1:0]      line_clr;
  logic [NUM_LINES-1:0]      pend;
  logic                      master_en;

  ext_irq_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(irq_pin), .q(pin_s)
  );

  ext_irq_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata), .rd_en(rd_en),
    .rdata(rdata), .line_en(line_en), .line_sense(line_sense),
    .line_clr(line_clr), .master_en(master_en), .route_crit(crit_route)
  );

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    ext_irq_line u_line (
      .clk(clk), .rst_n(rst_n), .pin_s(pin_s[n]), .sense(line_sense[n]),
      .en(line_en[n]), .master(master_en), .clr(line_clr[n]), .pend(pend[n])
    );
  end

  assign crit_pend = pend[0];
  assign main_pend = pend[NUM_LINES-1:1];

  AST_MASTER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !master_en |-> (pend == '0)); // R6
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !line_en[0] |-> !crit_pend); // R2
endmodule

// File: tb/ext_irq_ctrl_tb.sv
module ext_irq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic        rd_en = 1'b1;
  logic [31:0] rdata;
  logic [3:0]  irq_pin = '0;
  logic        crit_pend;
  logic [2:0]  main_pend;
  logic        crit_route;
  logic [3:0]  pend_v;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ext_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata), .rd_en(rd_en),
    .rdata(rdata), .irq_pin(irq_pin), .crit_pend(crit_pend),
    .main_pend(main_pend), .crit_route(crit_route)
  );

  assign pend_v = {main_pend, crit_pend};

  // {control word, pins, expected pending}; all entries use level modes
  localparam logic [39:0] VEC [5] = '{
    {32'h0000_1F00, 4'b0101, 4'b0101},  // R4 active high on all lines
    {32'h00FF_1F00, 4'b0101, 4'b1010},  // R4 active low on all lines
    {32'h0000_0F00, 4'b1111, 4'b0000},  // R6 master off
    {32'h0000_1500, 4'b1111, 4'b1010},  // R2 only lines 1 and 3 enabled
    {32'h00CC_1F00, 4'b0000, 4'b0101}   // R4 mixed per-line sense fields
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    cyc(3);
    chk("R1 rdata", rdata, 32'h0);
    chk("R1 pend", {28'h0, pend_v}, 32'h0);
    chk("R1 route", {31'h0, crit_route}, 32'h0);
    rst_n = 1'b1;
    cyc(2);

    for (int v = 0; v < 5; v++) begin
      @(negedge clk);
      irq_pin = VEC[v][7:4];
      wr(VEC[v][39:8]);
      cyc(4);
      chk("R2/R4/R6 vector", {28'h0, pend_v}, {28'h0, VEC[v][3:0]});
    end

    // R10 R3: reserved and clear bits read as zero
    irq_pin = 4'b0000;
    wr(32'hFFFF_FFFF);
    chk("R10 readback", rdata, 32'h00FF_1F01);
    chk("R7 route", {31'h0, crit_route}, 32'h1);
    wr(32'h0000_0001);
    chk("R7 route only", rdata, 32'h0000_0001);

    // rising edge on line 1, sticky
    wr(32'h0010_1F00);
    cyc(3);
    irq_pin = 4'b0010;
    cyc(4);
    chk("R4 rise sets", {28'h0, pend_v}, 32'h2);
    chk("R7 line1 on main_pend[0]", {29'h0, main_pend}, 32'h1);
    irq_pin = 4'b0000;
    cyc(4);
    chk("R5 sticky", {28'h0, pend_v}, 32'h2);
    wr(32'h0410_1F00);
    chk("R3 clear", {28'h0, pend_v}, 32'h0);
    chk("R3 reads zero", rdata, 32'h0010_1F00);

    // R6 latch survives master off
    irq_pin = 4'b0010;
    cyc(4);
    irq_pin = 4'b0000;
    wr(32'h0010_0F00);
    chk("R6 masked", {28'h0, pend_v}, 32'h0);
    wr(32'h0010_1F00);
    chk("R6 restored", {28'h0, pend_v}, 32'h2);

    // R8 same-cycle detection and clear
    cyc(2);
    irq_pin = 4'b0010;
    @(posedge clk);
    @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b1;
    wdata = 32'h0410_1F00;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    chk("R8 set wins", {28'h0, pend_v}, 32'h2);
    wr(32'h0410_1F00);
    chk("R8 later clear", {28'h0, pend_v}, 32'h0);

    // R9 latency: line 0 level high, line 1 rising
    irq_pin = 4'b0000;
    cyc(4);
    wr(32'h0410_1F00);
    irq_pin = 4'b0011;
    @(posedge clk); @(negedge clk);
    chk("R9 after 1 edge", {28'h0, pend_v}, 32'h0);
    @(posedge clk); @(negedge clk);
    chk("R9 level after 2", {28'h0, pend_v}, 32'h1);
    @(posedge clk); @(negedge clk);
    chk("R9 edge after 3", {28'h0, pend_v}, 32'h3);

    // R4 falling mode on line 3
    irq_pin = 4'b0000;
    wr(32'h0002_1F00);
    cyc(4);
    irq_pin = 4'b1000;
    cyc(4);
    chk("R4 fall ignores rise", {28'h0, pend_v}, 32'h0);
    irq_pin = 4'b0000;
    cyc(4);
    chk("R4 fall sets", {28'h0, pend_v}, 32'h8);

    done = 1'b1;
    finish_run();
  end
endmodule